// File: doc/BRIEF.md
# Reference-Counted Pad Power-Gate Sequencer

This block owns the power island of a pad group. It drives three gate controls: core power-down, early clamp and clamp. It also drives an active-high reset for the attached PHY. Several clients may share the pads, so the block keeps a use count. The first enable request wakes the island and the last disable request puts it to sleep. Requests in between only move the count.

Waking releases the clamp, then the early clamp, then core power-down, and finally releases the PHY reset. Sleeping runs the mirror order: PHY reset first, then core power-down, then the early clamp, then the clamp. Each step is held for a parameterised settle time. `busy_o` covers the whole run and `done_o` pulses when it ends. A disable request with no users outstanding, or an enable request with the count already at its ceiling, raises a one-cycle error pulse and changes nothing else.

Top module: `pad_pwr_seq`

## Requirements
- R1: After reset, `vcore_down_o`, `clamp_early_o`, `clamp_o` and `phy_rst_o` are 1, `busy_o`, `done_o`, `unbal_err_o` and `ovf_err_o` are 0, and the use count is zero.
- R2: Call the edge that samples an accepted enable request with a count of zero edge T, and let S be STEP_CYCLES. At edge T `clamp_o` falls, at T+S `clamp_early_o` falls, at T+2S `vcore_down_o` falls, and at T+3S `phy_rst_o` falls. The count becomes 1.
- R3: An accepted disable request with a count of 1, sampled at edge T, sets `phy_rst_o` at T, `vcore_down_o` at T+S, `clamp_early_o` at T+2S and `clamp_o` at T+3S. The count becomes 0.
- R4: An enable request with a count between 1 and its maximum raises the count by one, and a disable request with a count above 1 lowers it by one. Neither changes any output.
- R5: `busy_o` is 1 from edge T up to edge T+4S, where it falls. At that same edge `done_o` goes high for exactly one cycle.
- R6: Requests sampled while `busy_o` is 1 are dropped and leave the count unchanged.
- R7: A disable request with a count of zero raises `unbal_err_o` for one cycle and changes no gate, reset or busy output.
- R8: The count saturates at 2^CNT_W-1. An enable request at that value raises `ovf_err_o` for one cycle and leaves the count and all other outputs unchanged.
- R9: When an enable request and a disable request are sampled in the same cycle, the enable is handled and the disable is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_req_i | input | 1 | Enable request, sampled at each rising edge |
| dis_req_i | input | 1 | Disable request, sampled at each rising edge |
| busy_o | output | 1 | Wake or sleep sequence in progress |
| done_o | output | 1 | One-cycle pulse when a sequence ends |
| unbal_err_o | output | 1 | One-cycle pulse on a disable request with no users |
| ovf_err_o | output | 1 | One-cycle pulse on an enable request at a saturated count |
| vcore_down_o | output | 1 | Core power-down control |
| clamp_early_o | output | 1 | Early clamp enable |
| clamp_o | output | 1 | Clamp enable |
| phy_rst_o | output | 1 | PHY reset, active high |

## Verification
Every result is registered once. Error pulses, count changes and the first step of a sequence appear at the edge that samples the request. Each later step appears at a multiple of STEP_CYCLES after that edge, and `busy_o` falls with the `done_o` pulse at four times STEP_CYCLES. The bench drives inputs on falling edges and advances a behavioural model on the same rising edge as the design. It compares every output at the next falling edge, so each result is checked in the exact cycle it is due.

// File: rtl/pad_pwr_pkg.sv
package pad_pwr_pkg;

  typedef enum logic {
    DIR_WAKE  = 1'b0,
    DIR_SLEEP = 1'b1
  } seq_dir_e;

  // gate vector bit positions; wake walks them upward, sleep downward
  localparam int unsigned GATE_N     = 4;
  localparam int unsigned PH_W       = $clog2(GATE_N);
  localparam int unsigned IDX_CLAMP  = 0;
  localparam int unsigned IDX_EARLY  = 1;
  localparam int unsigned IDX_VCORE  = 2;
  localparam int unsigned IDX_PHYRST = 3;

  typedef logic [GATE_N-1:0] gate_vec_t;

  function automatic logic [PH_W-1:0] phase_bit(seq_dir_e d, logic [PH_W-1:0] k);
    return (d == DIR_WAKE) ? k : (PH_W'(GATE_N - 1) - k);
  endfunction

endpackage

// File: rtl/pad_step_timer.sv
module pad_step_timer #(
  parameter int unsigned STEP_CYCLES = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  output logic expired_o
);
  localparam int unsigned TW = (STEP_CYCLES > 1) ? $clog2(STEP_CYCLES) : 1;
  localparam logic [TW-1:0] RELOAD = TW'(STEP_CYCLES - 1);

  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= RELOAD;
    else if (cnt_q != '0)   cnt_q <= cnt_q - TW'(1);
  end

  assign expired_o = (cnt_q == '0);

  a_r5_reload_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (cnt_q == RELOAD));
endmodule

// File: rtl/pad_use_counter.sv
module pad_use_counter #(
  parameter int unsigned CNT_W = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic inc_i,
  input  logic dec_i,
  output logic zero_o,
  output logic one_o,
  output logic full_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= '0;
    else if (inc_i && !full_o)     cnt_q <= cnt_q + CNT_W'(1);
    else if (dec_i && !zero_o)     cnt_q <= cnt_q - CNT_W'(1);
  end

  assign zero_o = (cnt_q == '0);
  assign one_o  = (cnt_q == CNT_W'(1));
  assign full_o = (cnt_q == CNT_MAX);

  a_r8_no_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o |=> (cnt_q != '0) || $past(dec_i));
  a_r7_no_underflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    zero_o |=> (cnt_q == '0) || (cnt_q == CNT_W'(1)));
endmodule

// File: rtl/pad_gate_seq.sv
module pad_gate_seq
  import pad_pwr_pkg::*;
#(
  parameter int unsigned STEP_CYCLES = 4
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      start_i,
  input  seq_dir_e  dir_i,
  output gate_vec_t gate_o,
  output logic      busy_o,
  output logic      done_o
);
  localparam logic [PH_W-1:0] LAST = PH_W'(GATE_N - 1);

  logic            active_q;
  logic [PH_W-1:0] phase_q;
  seq_dir_e        dir_q;
  gate_vec_t       gate_q;
  logic            done_q;
  logic            expired;
  logic            launch;
  logic            advance;

  assign launch  = start_i && !active_q;
  assign advance = active_q && expired && (phase_q != LAST);

  pad_step_timer #(.STEP_CYCLES(STEP_CYCLES)) i_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (launch || advance),
    .expired_o(expired)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      phase_q  <= '0;
      dir_q    <= DIR_WAKE;
      gate_q   <= '1;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (launch) begin
        active_q <= 1'b1;
        dir_q    <= dir_i;
        phase_q  <= '0;
        gate_q[phase_bit(dir_i, '0)] <= (dir_i == DIR_SLEEP);
      end else if (advance) begin
        phase_q <= phase_q + PH_W'(1);
        gate_q[phase_bit(dir_q, phase_q + PH_W'(1))] <= (dir_q == DIR_SLEEP);
      end else if (active_q && expired) begin
        active_q <= 1'b0;
        done_q   <= 1'b1;
      end
    end
  end

  assign gate_o = gate_q;
  assign busy_o = active_q;
  assign done_o = done_q;

  a_r5_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);
  a_r5_done_at_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(active_q) |-> done_q);
  a_r6_one_bit_per_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(gate_q ^ $past(gate_q)) <= 1);
endmodule

// File: rtl/pad_pwr_seq.sv
module pad_pwr_seq
  import pad_pwr_pkg::*;
#(
  parameter int unsigned STEP_CYCLES = 4,
  parameter int unsigned CNT_W       = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_req_i,
  input  logic dis_req_i,
  output logic busy_o,
  output logic done_o,
  output logic unbal_err_o,
  output logic ovf_err_o,
  output logic vcore_down_o,
  output logic clamp_early_o,
  output logic clamp_o,
  output logic phy_rst_o
);
  logic      busy;
  logic      cnt_zero, cnt_one, cnt_full;
  logic      en_go, dis_go;
  logic      wake_go, sleep_go;
  logic      unbal_q, ovf_q;
  gate_vec_t gate;

  // enable wins over a simultaneous disable; nothing is taken while busy
  assign en_go    = en_req_i && !busy;
  assign dis_go   = dis_req_i && !en_req_i && !busy;
  assign wake_go  = en_go && cnt_zero;
  assign sleep_go = dis_go && cnt_one;

  pad_use_counter #(.CNT_W(CNT_W)) i_users (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .inc_i (en_go),
    .dec_i (dis_go),
    .zero_o(cnt_zero),
    .one_o (cnt_one),
    .full_o(cnt_full)
  );

  pad_gate_seq #(.STEP_CYCLES(STEP_CYCLES)) i_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(wake_go || sleep_go),
    .dir_i  (sleep_go ? DIR_SLEEP : DIR_WAKE),
    .gate_o (gate),
    .busy_o (busy),
    .done_o (done_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      unbal_q <= 1'b0;
      ovf_q   <= 1'b0;
    end else begin
      unbal_q <= dis_go && cnt_zero;
      ovf_q   <= en_go && cnt_full;
    end
  end

  assign busy_o        = busy;
  assign unbal_err_o   = unbal_q;
  assign ovf_err_o     = ovf_q;
  assign vcore_down_o  = gate[IDX_VCORE];
  assign clamp_early_o = gate[IDX_EARLY];
  assign clamp_o       = gate[IDX_CLAMP];
  assign phy_rst_o     = gate[IDX_PHYRST];

  a_r2_vcore_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(vcore_down_o) |-> !clamp_o && !clamp_early_o);
  a_r2_phy_release_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(phy_rst_o) |-> !vcore_down_o && !clamp_early_o && !clamp_o);
  a_r3_phy_reset_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(vcore_down_o) |-> phy_rst_o);
  a_r3_clamp_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(clamp_o) |-> vcore_down_o && clamp_early_o && phy_rst_o);
  a_r7_unbal_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unbal_err_o |-> $stable({vcore_down_o, clamp_early_o, clamp_o, phy_rst_o}) && !busy_o);
  a_r8_ovf_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_err_o |-> $stable({vcore_down_o, clamp_early_o, clamp_o, phy_rst_o}) && !busy_o);
  a_r7_err_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(unbal_err_o && ovf_err_o));
endmodule

// File: tb/test_pad_pwr_seq.sv
module test_pad_pwr_seq;
  localparam int CLK_PERIOD = 10;
  localparam int S          = 4;
  localparam int CNT_W      = 8;
  localparam int CNT_MAX    = (1 << CNT_W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0, dis = 1'b0;
  logic busy, done, unbal, ovf, vcore, early, clamp, prst;

  pad_pwr_seq #(.STEP_CYCLES(S), .CNT_W(CNT_W)) i_pad_pwr_seq (
    .clk_i(clk), .rst_ni(rst_n), .en_req_i(en), .dis_req_i(dis),
    .busy_o(busy), .done_o(done), .unbal_err_o(unbal), .ovf_err_o(ovf),
    .vcore_down_o(vcore), .clamp_early_o(early), .clamp_o(clamp), .phy_rst_o(prst)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  string tag = "R1";

  // behavioural reference
  int m_cnt, m_tick, m_dir;
  bit m_busy, m_done, m_unbal, m_ovf, m_vcore, m_early, m_clamp, m_prst;

  task automatic apply_step(int k);
    if (m_dir == 0) begin
      case (k)
        0: m_clamp = 0;
        1: m_early = 0;
        2: m_vcore = 0;
        default: m_prst = 0;
      endcase
    end else begin
      case (k)
        0: m_prst = 1;
        1: m_vcore = 1;
        2: m_early = 1;
        default: m_clamp = 1;
      endcase
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_tick = 0; m_dir = 0;
      m_busy = 0; m_done = 0; m_unbal = 0; m_ovf = 0;
      m_vcore = 1; m_early = 1; m_clamp = 1; m_prst = 1;
    end else begin
      m_done = 0; m_unbal = 0; m_ovf = 0;
      if (m_busy) begin
        m_tick++;
        if (m_tick % S == 0) begin
          if (m_tick / S == 4) begin m_busy = 0; m_done = 1; end
          else apply_step(m_tick / S);
        end
      end else if (en) begin
        if (m_cnt == 0) begin
          m_cnt = 1; m_busy = 1; m_dir = 0; m_tick = 0; apply_step(0);
        end else if (m_cnt == CNT_MAX) m_ovf = 1;
        else m_cnt++;
      end else if (dis) begin
        if (m_cnt == 0) m_unbal = 1;
        else if (m_cnt == 1) begin
          m_cnt = 0; m_busy = 1; m_dir = 1; m_tick = 0; apply_step(0);
        end else m_cnt--;
      end
    end
  end

  task automatic check(string sig, logic got, bit exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %b expected %b at %0t", tag, sig, got, exp, $time);
    end
  endtask

  always @(negedge clk) if (!finished) begin
    check("vcore_down", vcore, m_vcore);
    check("clamp_early", early, m_early);
    check("clamp", clamp, m_clamp);
    check("phy_rst", prst, m_prst);
    check("busy", busy, m_busy);
    check("done", done, m_done);
    check("unbal_err", unbal, m_unbal);
    check("ovf_err", ovf, m_ovf);
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic req(bit e, bit d);
    @(negedge clk); en = e; dis = d;
    @(negedge clk); en = 0; dis = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: got hung expected finish");
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    tag = "R1"; idle(3); rst_n = 1; idle(2);
    tag = "R2"; req(1, 0); idle(4*S + 3);             // wake from zero
    tag = "R4"; req(1, 0); req(1, 0); req(0, 1); req(0, 1); idle(3); // 3 then back to 1
    tag = "R3"; req(0, 1); idle(4*S + 3);             // last user leaves
    tag = "R7"; req(0, 1); idle(3);                   // unbalanced
    tag = "R6"; req(1, 0); req(0, 1); req(1, 0); idle(4*S + 3);
    req(0, 1); idle(4*S + 3);                         // count was still 1: sleeps
    tag = "R9"; req(1, 1); idle(4*S + 3);             // enable wins
    req(0, 1); idle(4*S + 3);
    tag = "R8"; req(1, 0); idle(4*S + 3);
    for (int i = 1; i < CNT_MAX; i++) req(1, 0);
    req(1, 0); req(1, 0); idle(3);                    // saturated: two overflow pulses
    req(0, 1); idle(3);                               // back below max, no sleep
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule